// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces data-memory addresses for a signal-processing datapath. It keeps four address pointers. Each pointer has its own buffer bounds, ring length and reversed-index width. On every access strobe it returns the effective address for the selected pointer. In the same cycle it forms the pointer's new value, which is stored at the clock edge. The available behaviours are:

- plain indirect access;
- signed pre-modification and post-modification;
- a bounded circular buffer given by start and end addresses;
- a power-of-two aligned ring given by a length;
- reversed-carry stepping, which walks radix-2 FFT data in bit-reversed order.

Because wraparound and reversed-index stepping happen alongside the access, an inner loop spends no instructions on address checks.

A separate configuration port loads any pointer, bound, length or reversed-index width. The memory itself and general address arithmetic live elsewhere.

Top module: `addrGenUnit`

## Requirements
- R1: Mode 0 (indirect): `effAddr` equals the selected pointer, and `nextPtr` equals it unchanged.
- R2: Mode 1 (post-modify): `effAddr` is the pointer, and the pointer becomes pointer plus `step`, with `step` read as two's complement.
- R3: Mode 2 (pre-modify): pointer plus `step` is both `effAddr` and the new pointer.
- R4: Mode 3 (bounded circular, post): `effAddr` is the pointer. The sum is pointer plus `step`. With `step` ≥ 0 and the sum above the end register, the pointer becomes the start register. With `step` < 0 and the sum below the start register, it becomes the end register. Otherwise it becomes the sum.
- R5: Mode 4 (aligned ring, post): `effAddr` is the pointer. Let k be the smallest value with 2^k ≥ length. The base is the pointer with its low k bits cleared. The offset below the base moves by `step` modulo length, and the high bits are kept.
- R6: Mode 5 (reversed carry, post): `effAddr` is the pointer. The low n bits (n = reversed-index width) are incremented with the carry running from bit n-1 toward bit 0, and `step` is ignored. With n=3, starting at 0, the effective addresses run 0,4,2,6,1,5,3,7.
- R7: In modes 1 and 2 the arithmetic wraps modulo 2^ADDR_W with no flag.
- R8: The value shown on `nextPtr` is the one the next access to that pointer starts from. Only the selected pointer changes.
- R9: With `accessEn` low, or with mode 6 or 7, no pointer changes. Modes 6 and 7 give `effAddr` equal to the pointer.
- R10: A configuration write loads a field of pointer `cfgReg`. The field codes are: 0 pointer, 1 start, 2 end, 3 length, 4 reversed-index width. If it loads the same pointer that an access updates, the configuration write wins.
- R11: After reset every pointer, bound, length and width is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| accessEn | input | 1 | access strobe |
| regSel | input | 2 | pointer selected for the access |
| mode | input | 3 | addressing mode code |
| step | input | 16 | signed modifier |
| cfgWe | input | 1 | configuration write strobe |
| cfgReg | input | 2 | pointer whose configuration is written |
| cfgField | input | 3 | configuration field code |
| cfgData | input | 16 | configuration value |
| effAddr | output | 16 | effective address of this access |
| nextPtr | output | 16 | value written back to the selected pointer |

## Verification
The properties take for granted several things about the inputs:

- A bounded buffer does not straddle the top or bottom of the address space.
- A ring length is at least one and no larger than half the address space.
- The step magnitude in the circular modes does not exceed the buffer span or the length.

The stimulus respects these limits. It places bounded buffers in the middle of the address space, uses steps of one or two inside rings of five entries, and keeps the reversed-index width at three bits. Pointer wrap at the top of the address space is exercised only in the linear modes.

// File: rtl/aguPkg.sv
package aguPkg;
  localparam logic [2:0] MODE_IND  = 3'd0;
  localparam logic [2:0] MODE_POST = 3'd1;
  localparam logic [2:0] MODE_PRE  = 3'd2;
  localparam logic [2:0] MODE_CIRC = 3'd3;
  localparam logic [2:0] MODE_RING = 3'd4;
  localparam logic [2:0] MODE_REV  = 3'd5;

  localparam logic [2:0] FLD_PTR   = 3'd0;
  localparam logic [2:0] FLD_START = 3'd1;
  localparam logic [2:0] FLD_END   = 3'd2;
  localparam logic [2:0] FLD_LEN   = 3'd3;
  localparam logic [2:0] FLD_REV   = 3'd4;

  typedef enum logic [1:0] {
    WRAP_LIN    = 2'd0,
    WRAP_BOUNDS = 2'd1,
    WRAP_RING   = 2'd2,
    WRAP_REV    = 2'd3
  } wrapKindT;

  typedef struct packed {
    logic     update;
    logic     preMod;
    wrapKindT wrapKind;
  } aguCtrlT;
endpackage

// File: rtl/aguCtrl.sv
module aguCtrl
  import aguPkg::*;
(
  input  logic       accessEn,
  input  logic [2:0] mode,
  output aguCtrlT    ctrl
);
  always_comb begin
    ctrl = '{update: 1'b0, preMod: 1'b0, wrapKind: WRAP_LIN};
    case (mode)
      MODE_POST: ctrl.update = accessEn;
      MODE_PRE: begin
        ctrl.update = accessEn;
        ctrl.preMod = 1'b1;
      end
      MODE_CIRC: begin
        ctrl.update   = accessEn;
        ctrl.wrapKind = WRAP_BOUNDS;
      end
      MODE_RING: begin
        ctrl.update   = accessEn;
        ctrl.wrapKind = WRAP_RING;
      end
      MODE_REV: begin
        ctrl.update   = accessEn;
        ctrl.wrapKind = WRAP_REV;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aguDatapath.sv
module aguDatapath
  import aguPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = $clog2(NUM_REGS),
  parameter int REV_W    = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguCtrlT           ctrl,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] step,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgReg,
  input  logic [2:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] nextPtr
);
  logic [ADDR_W-1:0] ptrQ   [NUM_REGS];
  logic [ADDR_W-1:0] startQ [NUM_REGS];
  logic [ADDR_W-1:0] endQ   [NUM_REGS];
  logic [ADDR_W-1:0] lenQ   [NUM_REGS];
  logic [REV_W-1:0]  revQ   [NUM_REGS];

  logic [ADDR_W-1:0] curPtr, curStart, curEnd, curLen;
  logic [REV_W-1:0]  curRev;
  logic              stepNeg;
  logic [ADDR_W-1:0] linSum, boundsNext, ringMask, ringNext, revNext, modNext;
  logic [ADDR_W:0]   ringOff, ringAdj, lenWide;
  logic              carry;

  always_comb begin
    curPtr   = ptrQ[regSel];
    curStart = startQ[regSel];
    curEnd   = endQ[regSel];
    curLen   = lenQ[regSel];
    curRev   = revQ[regSel];
    stepNeg  = step[ADDR_W-1];
    linSum   = curPtr + step;

    // bounded circular buffer
    if (!stepNeg && linSum > curEnd)      boundsNext = curStart;
    else if (stepNeg && linSum < curStart) boundsNext = curEnd;
    else                                   boundsNext = linSum;

    // aligned ring: mask covers the smallest power of two >= length
    for (int i = 0; i < ADDR_W; i++)
      ringMask[i] = (((ADDR_W + 1)'(1)) << i) < {1'b0, curLen};
    lenWide = {1'b0, curLen};
    ringOff = {1'b0, curPtr & ringMask} + {stepNeg, step};
    if (ringOff[ADDR_W])        ringAdj = ringOff + lenWide;
    else if (ringOff >= lenWide) ringAdj = ringOff - lenWide;
    else                         ringAdj = ringOff;
    ringNext = (curPtr & ~ringMask) | (ringAdj[ADDR_W-1:0] & ringMask);

    // reversed-carry increment over the low curRev bits
    carry = 1'b1;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      if (i < int'(curRev)) begin
        revNext[i] = curPtr[i] ^ carry;
        carry      = curPtr[i] & carry;
      end else begin
        revNext[i] = curPtr[i];
      end
    end

    case (ctrl.wrapKind)
      WRAP_BOUNDS: modNext = boundsNext;
      WRAP_RING:   modNext = ringNext;
      WRAP_REV:    modNext = revNext;
      default:     modNext = linSum;
    endcase

    effAddr = ctrl.preMod ? modNext : curPtr;
    nextPtr = ctrl.update ? modNext : curPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        ptrQ[r]   <= '0;
        startQ[r] <= '0;
        endQ[r]   <= '0;
        lenQ[r]   <= '0;
        revQ[r]   <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (ctrl.update && regSel == SEL_W'(r))
          ptrQ[r] <= nextPtr;
        if (cfgWe && cfgReg == SEL_W'(r)) begin
          case (cfgField)
            FLD_PTR:   ptrQ[r]   <= cfgData;
            FLD_START: startQ[r] <= cfgData;
            FLD_END:   endQ[r]   <= cfgData;
            FLD_LEN:   lenQ[r]   <= cfgData;
            FLD_REV:   revQ[r]   <= cfgData[REV_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/addrGenUnit.sv
module addrGenUnit
  import aguPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] step,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgReg,
  input  logic [2:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] nextPtr
);
  aguCtrlT ctrl;

  aguCtrl u_ctrl (
    .accessEn (accessEn),
    .mode     (mode),
    .ctrl     (ctrl)
  );

  aguDatapath #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .regSel   (regSel),
    .step     (step),
    .cfgWe    (cfgWe),
    .cfgReg   (cfgReg),
    .cfgField (cfgField),
    .cfgData  (cfgData),
    .effAddr  (effAddr),
    .nextPtr  (nextPtr)
  );
endmodule

// File: rtl/aguChecker.sv
module aguChecker #(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              accessEn,
  input logic [SEL_W-1:0]  regSel,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] step,
  input logic              cfgWe,
  input logic [ADDR_W-1:0] effAddr,
  input logic [ADDR_W-1:0] nextPtr
);
  AST_INDIRECT_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && mode == 3'd0) |-> (nextPtr == effAddr)); // R1

  AST_POST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && mode == 3'd1) |-> (nextPtr == ADDR_W'(effAddr + step))); // R2

  AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && mode == 3'd2) |-> (effAddr == nextPtr)); // R3

  AST_RESERVED_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && mode >= 3'd6) |-> (nextPtr == effAddr)); // R9

  AST_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && $past(accessEn) && regSel == $past(regSel) && !$past(cfgWe)
     && mode != 3'd2) |-> (effAddr == $past(nextPtr))); // R8
endmodule

bind addrGenUnit aguChecker #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accessEn (accessEn),
  .regSel   (regSel),
  .mode     (mode),
  .step     (step),
  .cfgWe    (cfgWe),
  .effAddr  (effAddr),
  .nextPtr  (nextPtr)
);

// File: tb/addrGenUnit_tb.sv
module addrGenUnit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int MASK = 32'h0000_FFFF;

  logic clk = 1'b0, rstN = 1'b0;
  logic accessEn = 1'b0, cfgWe = 1'b0;
  logic [1:0] regSel = '0, cfgReg = '0;
  logic [2:0] mode = '0, cfgField = '0;
  logic [W-1:0] step = '0, cfgData = '0;
  logic [W-1:0] effAddr, nextPtr;

  int checks = 0, errors = 0;
  int ptrM[4], startM[4], endM[4], lenM[4], revM[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  addrGenUnit u_dut (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .regSel(regSel), .mode(mode),
    .step(step), .cfgWe(cfgWe), .cfgReg(cfgReg), .cfgField(cfgField),
    .cfgData(cfgData), .effAddr(effAddr), .nextPtr(nextPtr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int revBits(int v, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if ((v >> i) & 1) r |= 1 << (n - 1 - i);
    return r;
  endfunction

  function automatic void model(int sel, int md, int s, output int ea, output int np);
    int p, t, k, base, off, lo;
    p = ptrM[sel];
    ea = p;
    np = p;
    case (md)
      1: np = (p + s) & MASK;
      2: begin np = (p + s) & MASK; ea = np; end
      3: begin
        t = p + s;
        if (s >= 0 && t > endM[sel]) t = startM[sel];
        else if (s < 0 && t < startM[sel]) t = endM[sel];
        np = t & MASK;
      end
      4: begin
        k = 0;
        while ((1 << k) < lenM[sel]) k++;
        base = p & ~((1 << k) - 1);
        off = (p - base) + s;
        if (off < 0) off += lenM[sel];
        else if (off >= lenM[sel]) off -= lenM[sel];
        np = base + off;
      end
      5: begin
        lo = revBits(revBits(p & ((1 << revM[sel]) - 1), revM[sel]) + 1, revM[sel]);
        np = (p & ~((1 << revM[sel]) - 1)) | (lo & ((1 << revM[sel]) - 1));
      end
      default: ;
    endcase
  endfunction

  task automatic access(int sel, int md, int s, string req, output int eaOut);
    int ea, np;
    @(negedge clk);
    regSel = 2'(sel); mode = 3'(md); step = W'(s); accessEn = 1'b1;
    #1;
    model(sel, md, s, ea, np);
    check({req, " effAddr"}, int'(effAddr), ea);
    check({req, " nextPtr"}, int'(nextPtr), np);
    eaOut = int'(effAddr);
    @(posedge clk);
    if (md >= 1 && md <= 5) ptrM[sel] = np;
    #1 accessEn = 1'b0;
  endtask

  task automatic cfg(int sel, int fld, int val);
    @(negedge clk);
    cfgReg = 2'(sel); cfgField = 3'(fld); cfgData = W'(val); cfgWe = 1'b1;
    @(posedge clk);
    case (fld)
      0: ptrM[sel] = val;
      1: startM[sel] = val;
      2: endM[sel] = val;
      3: lenM[sel] = val;
      default: revM[sel] = val;
    endcase
    #1 cfgWe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ea;
    int revExp[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    for (int r = 0; r < 4; r++) begin
      ptrM[r] = 0; startM[r] = 0; endM[r] = 0; lenM[r] = 0; revM[r] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R11 reset state
    for (int r = 0; r < 4; r++) begin
      access(r, 0, 0, "R11 reset", ea);
      check("R11 reset pointer", ea, 0);
    end

    // R1, R2, R3, R8 linear modes
    cfg(0, 0, 16'h1000);
    access(0, 0, 7, "R1 indirect", ea);
    access(0, 1, 1, "R2 post +1", ea);
    access(0, 1, 3, "R2 post +3", ea);
    access(0, 1, -2, "R2 post -2", ea);
    access(0, 2, 4, "R3 pre +4", ea);
    access(0, 2, -1, "R3 pre -1", ea);
    access(0, 0, 0, "R8 writeback", ea);
    check("R8 writeback value", ea, 16'h1005);

    // R7 wrap
    cfg(1, 0, 16'hFFFE);
    access(1, 1, 3, "R7 post wrap up", ea);
    access(1, 2, -2, "R7 pre wrap down", ea);
    access(1, 0, 0, "R7 wrapped", ea);
    check("R7 wrapped value", ea, 16'hFFFF);

    // R8 independence: pointer 0 untouched
    access(0, 0, 0, "R8 independent", ea);
    check("R8 independent value", ea, 16'h1005);

    // R4 bounded circular
    cfg(2, 1, 16'h0100);
    cfg(2, 2, 16'h0104);
    cfg(2, 0, 16'h0102);
    for (int i = 0; i < 6; i++) access(2, 3, 1, "R4 circular up", ea);
    for (int i = 0; i < 7; i++) access(2, 3, -1, "R4 circular down", ea);
    access(2, 3, 2, "R4 circular +2", ea);

    // R5 aligned ring, length 5 at 0x0208
    cfg(3, 3, 5);
    cfg(3, 0, 16'h020B);
    for (int i = 0; i < 4; i++) access(3, 4, 1, "R5 ring up", ea);
    access(3, 0, 0, "R5 ring wrapped", ea);
    check("R5 ring wrapped value", ea, 16'h020A);
    for (int i = 0; i < 4; i++) access(3, 4, -2, "R5 ring down", ea);
    access(3, 4, 2, "R5 ring +2", ea);

    // R6 reversed carry, 3 bits
    cfg(1, 4, 3);
    cfg(1, 0, 16'h0040);
    for (int i = 0; i < 8; i++) begin
      access(1, 5, 9, "R6 reversed", ea);
      check("R6 reversed sequence", ea, 16'h0040 + revExp[i]);
    end
    access(1, 0, 0, "R6 rolled over", ea);
    check("R6 rolled over value", ea, 16'h0040);

    // R9 strobe low and reserved modes
    @(negedge clk);
    regSel = 2'd0; mode = 3'd1; step = W'(5); accessEn = 1'b0;
    @(posedge clk);
    access(0, 0, 0, "R9 strobe low", ea);
    check("R9 strobe low value", ea, 16'h1005);
    access(0, 6, 3, "R9 reserved 6", ea);
    access(0, 7, 3, "R9 reserved 7", ea);
    access(0, 0, 0, "R9 reserved held", ea);
    check("R9 reserved held value", ea, 16'h1005);

    // R10 configuration beats access on same pointer
    @(negedge clk);
    regSel = 2'd2; mode = 3'd1; step = W'(1); accessEn = 1'b1;
    cfgReg = 2'd2; cfgField = 3'd0; cfgData = W'(16'h0555); cfgWe = 1'b1;
    @(posedge clk);
    ptrM[2] = 16'h0555;
    #1 begin accessEn = 1'b0; cfgWe = 1'b0; end
    access(2, 0, 0, "R10 config wins", ea);
    check("R10 config wins value", ea, 16'h0555);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule